// File: doc/BRIEF.md
# 16-bit Word Command Decoder

This block sits on the device side of a host command channel that carries 16-bit words. It parses a word stream into five commands: register write, register read, memory read, status read and capture setup. It executes each command against a small register file, a memory request port, a status input bus and a setup write port. Values wider than 16 bits are carried as pairs or quadruples of 16-bit halves, with the low half first.

Replies to register reads and status reads leave on a valid/ready word stream. While a reply is pending, the input stream is held off. Three read-only self-test registers return fixed patterns, so bring-up software can confirm that the link and the decoder work before it uses the block.

Top module: `cmdw_decoder`

## Requirements
- R1: After reset, cmd_ready_o is 1, and rsp_valid_o, reg_we_o, mem_req_o and setup_we_o are 0.
- R2: The register write command has 4 words: code 0x0001, register index, value bits 15:0, value bits 31:16. The cycle after the last word is accepted, reg_we_o pulses for one cycle with reg_idx_o equal to the index and reg_wdata_o equal to the value.
- R3: The register read command has 2 words: code 0x0002, then the register index. Its reply is 2 words: value bits 15:0, then bits 31:16. For an index below NREG, the value is the last one written.
- R4: Indices 0x0010, 0x0011 and 0x0012 read 0x12345678, 0x12345678 and 0x87654321. Writes to these indices do not change what they read.
- R5: The memory read command has 5 words: code 0x0003, address low, address high, count low, count high. It produces a one-cycle mem_req_o pulse with the 32-bit mem_addr_o and mem_cnt_o.
- R6: The status read command has 3 words: code 0x0004, start address A, length L in 64-bit words. Its reply is 4*L words. For word k, the value is status word A+k (bits 64*(A+k) upward of status_i), or 0 when A+k >= NSTAT, sent as 16-bit quarters from bits 15:0 up to bits 63:48. When L is 0 there is no reply.
- R7: The capture setup command has 3 words: code 0x0005, start address A, length L. These are followed by 4*L payload words. Each group of 4 is assembled with its first word in bits 15:0, and produces a one-cycle setup_we_o pulse with setup_addr_o = A+k. When L is 0 there is no payload.
- R8: A command code other than 0x0001 to 0x0005 is dropped, and the next word is decoded as a command code.
- R9: While a reply is pending, cmd_ready_o is 0, until the last reply word is accepted. Under backpressure, rsp_data_o holds steady.
- R10: A write to an index that is neither below NREG nor a self-test index still produces the strobe, but it changes no stored register. A read of such an index returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_data_i | input | 16 | Command word |
| cmd_valid_i | input | 1 | Command word valid |
| cmd_ready_o | output | 1 | Decoder accepts a word |
| rsp_data_o | output | 16 | Reply word |
| rsp_valid_o | output | 1 | Reply word valid |
| rsp_ready_i | input | 1 | Receiver accepts a reply word |
| reg_we_o | output | 1 | Register write strobe |
| reg_idx_o | output | 16 | Register write index |
| reg_wdata_o | output | 32 | Register write value |
| mem_req_o | output | 1 | Memory read request pulse |
| mem_addr_o | output | 32 | Memory read start address |
| mem_cnt_o | output | 32 | Memory read word count |
| setup_we_o | output | 1 | Setup word write strobe |
| setup_addr_o | output | 16 | Setup word address |
| setup_data_o | output | 64 | Assembled setup word |
| status_i | input | NSTAT*64 | Status words, word i at bits 64*i upward |

## Verification
The hardest case to reach is a multi-word status reply that is stalled partway through. At that point the decoder must keep the input stream closed and hold the current reply word, while its 64-bit word sequencer waits between quarters. The stimulus reaches it by switching the reply receiver into a periodic backpressure pattern during a long status read. The read runs past the end of the status bus, so the zero-fill path and a stalled word boundary occur in the same reply.

// File: rtl/cmdw_pkg.sv
package cmdw_pkg;
  localparam logic [15:0] OP_WR    = 16'h0001;
  localparam logic [15:0] OP_RD    = 16'h0002;
  localparam logic [15:0] OP_MEM   = 16'h0003;
  localparam logic [15:0] OP_STAT  = 16'h0004;
  localparam logic [15:0] OP_SETUP = 16'h0005;

  localparam logic [15:0] ST_IDX0 = 16'h0010;
  localparam logic [15:0] ST_IDX1 = 16'h0011;
  localparam logic [15:0] ST_IDX2 = 16'h0012;
  localparam logic [31:0] ST_VAL0 = 32'h1234_5678;
  localparam logic [31:0] ST_VAL1 = 32'h1234_5678;
  localparam logic [31:0] ST_VAL2 = 32'h8765_4321;

  typedef enum logic [1:0] {S_CMD, S_ARG, S_DATA, S_REPLY} pstate_e;

  function automatic logic is_known(input logic [15:0] c);
    return (c >= OP_WR) && (c <= OP_SETUP);
  endfunction

  // index of the final header argument after the code word
  function automatic logic [1:0] last_arg(input logic [15:0] c);
    case (c)
      OP_WR:   return 2'd2;
      OP_MEM:  return 2'd3;
      OP_STAT, OP_SETUP: return 2'd1;
      default: return 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/cmdw_reg_bank.sv
module cmdw_reg_bank
  import cmdw_pkg::*;
#(
  parameter int NREG = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        we_i,
  input  logic [15:0] widx_i,
  input  logic [31:0] wdata_i,
  input  logic [15:0] ridx_i,
  output logic [31:0] rdata_o
);
  localparam int RW = (NREG > 1) ? $clog2(NREG) : 1;

  logic [31:0] regs_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (we_i && (widx_i < 16'(NREG))) begin
      regs_q[widx_i[RW-1:0]] <= wdata_i;
    end
  end

  always_comb begin
    if (ridx_i < 16'(NREG)) rdata_o = regs_q[ridx_i[RW-1:0]];
    else if (ridx_i == ST_IDX0) rdata_o = ST_VAL0;
    else if (ridx_i == ST_IDX1) rdata_o = ST_VAL1;
    else if (ridx_i == ST_IDX2) rdata_o = ST_VAL2;
    else rdata_o = '0;
  end
endmodule

// File: rtl/cmdw_reply_ser.sv
module cmdw_reply_ser (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        load_i,
  input  logic [63:0] load_data_i,
  input  logic [2:0]  load_halves_i,
  output logic        busy_o,
  output logic [15:0] rsp_data_o,
  output logic        rsp_valid_o,
  input  logic        rsp_ready_i
);
  logic [63:0] sh_q;
  logic [2:0]  left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= load_data_i;
      left_q <= load_halves_i;
    end else if (rsp_valid_o && rsp_ready_i) begin
      sh_q   <= {16'h0, sh_q[63:16]};
      left_q <= left_q - 3'd1;
    end
  end

  assign busy_o      = (left_q != 3'd0);
  assign rsp_valid_o = busy_o;
  assign rsp_data_o  = sh_q[15:0];

  // R9
  load_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> !busy_o);
  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_data_o)));
endmodule

// File: rtl/cmdw_decoder.sv
module cmdw_decoder
  import cmdw_pkg::*;
#(
  parameter int NREG  = 8,
  parameter int NSTAT = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [15:0]        cmd_data_i,
  input  logic               cmd_valid_i,
  output logic               cmd_ready_o,
  output logic [15:0]        rsp_data_o,
  output logic               rsp_valid_o,
  input  logic               rsp_ready_i,
  output logic               reg_we_o,
  output logic [15:0]        reg_idx_o,
  output logic [31:0]        reg_wdata_o,
  output logic               mem_req_o,
  output logic [31:0]        mem_addr_o,
  output logic [31:0]        mem_cnt_o,
  output logic               setup_we_o,
  output logic [15:0]        setup_addr_o,
  output logic [63:0]        setup_data_o,
  input  logic [NSTAT*64-1:0] status_i
);
  localparam int SW = (NSTAT > 1) ? $clog2(NSTAT) : 1;

  pstate_e     state_q;
  logic [15:0] op_q, cur_addr_q, words_left_q;
  logic [1:0]  aidx_q, hcnt_q;
  logic [15:0] args_q [4];
  logic [47:0] acc_q;
  logic        fire, ser_busy, ser_load;
  logic [63:0] ser_data, stat_word;
  logic [31:0] reg_rdata;
  logic [63:0] stat_arr [NSTAT];

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    assign stat_arr[g] = status_i[g*64 +: 64];
  end

  assign stat_word   = (cur_addr_q < 16'(NSTAT)) ? stat_arr[cur_addr_q[SW-1:0]] : 64'h0;
  assign cmd_ready_o = (state_q != S_REPLY);
  assign fire        = cmd_valid_i && cmd_ready_o;
  assign ser_load    = (state_q == S_REPLY) && !ser_busy && (words_left_q != 16'h0);
  assign ser_data    = (op_q == OP_RD) ? {32'h0, reg_rdata} : stat_word;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= S_CMD;
      op_q         <= '0;
      aidx_q       <= '0;
      hcnt_q       <= '0;
      cur_addr_q   <= '0;
      words_left_q <= '0;
      acc_q        <= '0;
      for (int i = 0; i < 4; i++) args_q[i] <= '0;
      reg_we_o     <= 1'b0;
      reg_idx_o    <= '0;
      reg_wdata_o  <= '0;
      mem_req_o    <= 1'b0;
      mem_addr_o   <= '0;
      mem_cnt_o    <= '0;
      setup_we_o   <= 1'b0;
      setup_addr_o <= '0;
      setup_data_o <= '0;
    end else begin
      reg_we_o   <= 1'b0;
      mem_req_o  <= 1'b0;
      setup_we_o <= 1'b0;
      case (state_q)
        S_CMD: if (fire && is_known(cmd_data_i)) begin
          op_q    <= cmd_data_i;
          aidx_q  <= '0;
          state_q <= S_ARG;
        end
        S_ARG: if (fire) begin
          args_q[aidx_q] <= cmd_data_i;
          aidx_q         <= aidx_q + 2'd1;
          if (aidx_q == last_arg(op_q)) begin
            case (op_q)
              OP_WR: begin
                reg_we_o    <= 1'b1;
                reg_idx_o   <= args_q[0];
                reg_wdata_o <= {cmd_data_i, args_q[1]};
                state_q     <= S_CMD;
              end
              OP_RD: begin
                cur_addr_q   <= cmd_data_i;
                words_left_q <= 16'd1;
                state_q      <= S_REPLY;
              end
              OP_MEM: begin
                mem_req_o  <= 1'b1;
                mem_addr_o <= {args_q[1], args_q[0]};
                mem_cnt_o  <= {cmd_data_i, args_q[2]};
                state_q    <= S_CMD;
              end
              OP_STAT: begin
                cur_addr_q   <= args_q[0];
                words_left_q <= cmd_data_i;
                state_q      <= (cmd_data_i == 16'h0) ? S_CMD : S_REPLY;
              end
              default: begin
                cur_addr_q   <= args_q[0];
                words_left_q <= cmd_data_i;
                hcnt_q       <= '0;
                state_q      <= (cmd_data_i == 16'h0) ? S_CMD : S_DATA;
              end
            endcase
          end
        end
        S_DATA: if (fire) begin
          acc_q  <= {cmd_data_i, acc_q[47:16]};
          hcnt_q <= hcnt_q + 2'd1;
          if (hcnt_q == 2'd3) begin
            setup_we_o   <= 1'b1;
            setup_addr_o <= cur_addr_q;
            setup_data_o <= {cmd_data_i, acc_q};
            cur_addr_q   <= cur_addr_q + 16'd1;
            words_left_q <= words_left_q - 16'd1;
            if (words_left_q == 16'd1) state_q <= S_CMD;
          end
        end
        default: if (!ser_busy) begin
          if (words_left_q == 16'h0) begin
            state_q <= S_CMD;
          end else begin
            words_left_q <= words_left_q - 16'd1;
            if (op_q != OP_RD) cur_addr_q <= cur_addr_q + 16'd1;
          end
        end
      endcase
    end
  end

  cmdw_reg_bank #(.NREG(NREG)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_o),
    .widx_i  (reg_idx_o),
    .wdata_i (reg_wdata_o),
    .ridx_i  (cur_addr_q),
    .rdata_o (reg_rdata)
  );

  cmdw_reply_ser u_ser (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .load_i        (ser_load),
    .load_data_i   (ser_data),
    .load_halves_i ((op_q == OP_RD) ? 3'd2 : 3'd4),
    .busy_o        (ser_busy),
    .rsp_data_o    (rsp_data_o),
    .rsp_valid_o   (rsp_valid_o),
    .rsp_ready_i   (rsp_ready_i)
  );

  // R9
  ready_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !cmd_ready_o);
  // R2
  wr_after_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(cmd_valid_i && cmd_ready_o));
  // R5
  mem_after_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $past(cmd_valid_i && cmd_ready_o));
  // R7
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_we_o, mem_req_o, setup_we_o}));
  // R8
  unknown_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CMD && fire && !is_known(cmd_data_i)) |=> (state_q == S_CMD));
endmodule

// File: tb/sim_cmdw_decoder.sv
`timescale 1ns/1ps
module sim_cmdw_decoder;
  localparam int NREG = 8;
  localparam int NSTAT = 16;

  typedef struct {
    logic [95:0] d;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] cmd_data = '0;
  logic cmd_valid = 1'b0, rsp_ready = 1'b1, bp_mode = 1'b0;
  logic cmd_ready, rsp_valid, reg_we, mem_req, setup_we;
  logic [15:0] rsp_data, reg_idx, setup_addr;
  logic [31:0] reg_wdata, mem_addr, mem_cnt;
  logic [63:0] setup_data;
  logic [NSTAT*64-1:0] status;
  int checks = 0, errors = 0, cyc = 0;
  logic [31:0] mdl [NREG];
  exp_t wr_q[$], mem_q[$], su_q[$], rsp_q[$];
  logic prev_stall = 1'b0;
  logic [15:0] prev_data = '0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cmdw_decoder #(.NREG(NREG), .NSTAT(NSTAT)) u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cmd_data_i(cmd_data), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .rsp_data_o(rsp_data), .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready),
    .reg_we_o(reg_we), .reg_idx_o(reg_idx), .reg_wdata_o(reg_wdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_cnt_o(mem_cnt),
    .setup_we_o(setup_we), .setup_addr_o(setup_addr), .setup_data_o(setup_data),
    .status_i(status)
  );

  function automatic logic [63:0] sw(input int i);
    return {16'(i * 3 + 1), 16'hC0DE, 16'(i), 16'(16'h5A00 + i)};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2 rsp_ready <= bp_mode ? (cyc % 3 != 1) : 1'b1;
  end

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    exp_t e;
    if (reg_we) begin
      if (wr_q.size() == 0) chk(0, "R2 unexpected write", {reg_idx, reg_wdata}, 0);
      else begin e = wr_q.pop_front(); chk({reg_idx, reg_wdata} == e.d[47:0], e.tag, {reg_idx, reg_wdata}, e.d); end
    end
    if (mem_req) begin
      if (mem_q.size() == 0) chk(0, "R5 unexpected request", {mem_addr, mem_cnt}, 0);
      else begin e = mem_q.pop_front(); chk({mem_addr, mem_cnt} == e.d[63:0], e.tag, {mem_addr, mem_cnt}, e.d); end
    end
    if (setup_we) begin
      if (su_q.size() == 0) chk(0, "R7 unexpected setup", {setup_addr, setup_data}, 0);
      else begin e = su_q.pop_front(); chk({setup_addr, setup_data} == e.d[79:0], e.tag, {setup_addr, setup_data}, e.d); end
    end
    if (prev_stall && rsp_valid) chk(rsp_data == prev_data, "R9 hold under stall", rsp_data, prev_data);
    if (rsp_valid && rsp_ready) begin
      chk(!cmd_ready, "R9 input closed during reply", cmd_ready, 0);
      if (rsp_q.size() == 0) chk(0, "R6 unexpected reply", rsp_data, 0);
      else begin e = rsp_q.pop_front(); chk(rsp_data == e.d[15:0], e.tag, rsp_data, e.d); end
    end
    prev_stall = rsp_valid && !rsp_ready;
    prev_data  = rsp_data;
  end

  task automatic put(input logic [15:0] w);
    cmd_data  = w;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic push_rsp(input logic [15:0] w, input string tag);
    exp_t e;
    e.d = 96'(w); e.tag = tag;
    rsp_q.push_back(e);
  endtask

  task automatic do_wr(input logic [15:0] idx, input logic [31:0] v);
    exp_t e;
    e.d = 96'({idx, v}); e.tag = "R2 write strobe";
    wr_q.push_back(e);
    if (idx < 16'(NREG)) mdl[idx[2:0]] = v;
    put(16'h0001); put(idx); put(v[15:0]); put(v[31:16]);
  endtask

  function automatic logic [31:0] exp_rd(input logic [15:0] idx);
    if (idx < 16'(NREG)) return mdl[idx[2:0]];
    if (idx == 16'h0010 || idx == 16'h0011) return 32'h1234_5678;
    if (idx == 16'h0012) return 32'h8765_4321;
    return 32'h0;
  endfunction

  task automatic do_rd(input logic [15:0] idx, input string tag);
    logic [31:0] v;
    v = exp_rd(idx);
    push_rsp(v[15:0], tag);
    push_rsp(v[31:16], tag);
    put(16'h0002); put(idx);
  endtask

  task automatic do_mem(input logic [31:0] a, input logic [31:0] n);
    exp_t e;
    e.d = 96'({a, n}); e.tag = "R5 memory request";
    mem_q.push_back(e);
    put(16'h0003); put(a[15:0]); put(a[31:16]); put(n[15:0]); put(n[31:16]);
  endtask

  task automatic do_stat(input int a, input int len);
    logic [63:0] v;
    for (int k = 0; k < len; k++) begin
      v = (a + k < NSTAT) ? sw(a + k) : 64'h0;
      for (int q = 0; q < 4; q++) push_rsp(v[q*16 +: 16], "R6 status word");
    end
    put(16'h0004); put(16'(a)); put(16'(len));
  endtask

  task automatic do_setup(input int a, input int len);
    exp_t e;
    logic [63:0] v;
    put(16'h0005); put(16'(a)); put(16'(len));
    for (int k = 0; k < len; k++) begin
      v = {16'(16'h7700 + k), 16'hBEEF, 16'(k * 5), 16'(16'h1100 + a)};
      e.d = 96'({16'(a + k), v}); e.tag = "R7 setup strobe";
      su_q.push_back(e);
      for (int q = 0; q < 4; q++) put(v[q*16 +: 16]);
    end
  endtask

  task automatic drain();
    int n = 0;
    while ((rsp_q.size() != 0 || rsp_valid || wr_q.size() != 0 ||
            mem_q.size() != 0 || su_q.size() != 0) && n < 2000) begin
      @(negedge clk); n++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < NSTAT; i++) status[i*64 +: 64] = sw(i);
    for (int i = 0; i < NREG; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(cmd_ready == 1'b1, "R1 ready after reset", cmd_ready, 1);
    chk(rsp_valid == 1'b0, "R1 no reply after reset", rsp_valid, 0);
    chk({reg_we, mem_req, setup_we} == 3'b000, "R1 strobes idle", {reg_we, mem_req, setup_we}, 0);

    // R2 R3
    for (int i = 0; i < NREG; i++) do_wr(16'(i), 32'hA5A5_0000 + 32'(i * 32'h0001_0011));
    do_rd(16'd0, "R3 read reg0 low then high");
    do_rd(16'd5, "R3 read reg5");
    do_wr(16'd5, 32'hFFFF_0001);
    do_rd(16'd5, "R3 read after rewrite");
    do_rd(16'd7, "R3 read reg7");

    // R4
    do_rd(16'h0010, "R4 self-test 0");
    do_rd(16'h0011, "R4 self-test 1");
    do_rd(16'h0012, "R4 self-test 2");
    do_wr(16'h0012, 32'hDEAD_BEEF);
    do_rd(16'h0012, "R4 self-test after write");

    // R10
    do_wr(16'd20, 32'h0BAD_CAFE);
    do_rd(16'd20, "R10 out-of-range read zero");
    do_rd(16'd4, "R10 alias reg untouched");

    // R5
    do_mem(32'h0000_0004, 32'h0000_0100);
    do_mem(32'hFEDC_BA98, 32'h8001_0002);

    // R6
    do_stat(5, 5);
    do_stat(14, 3);
    do_stat(3, 0);
    do_rd(16'd1, "R6 zero-length status then read");

    // R7
    do_setup(2, 3);
    do_setup(9, 0);
    do_rd(16'd2, "R7 decoder back in command state");

    // R8
    put(16'h0000); put(16'h0007); put(16'hFFFF);
    do_rd(16'd3, "R8 read after unknown codes");
    put(16'h0009);
    do_mem(32'h0000_1234, 32'h0000_0008);

    // R9
    drain();
    bp_mode = 1'b1;
    do_stat(12, 6);
    do_rd(16'h0011, "R9 read under backpressure");
    drain();
    bp_mode = 1'b0;

    drain();
    chk(rsp_q.size() == 0, "R6 all replies seen", rsp_q.size(), 0);
    chk(wr_q.size() == 0, "R2 all writes seen", wr_q.size(), 0);
    chk(mem_q.size() == 0, "R5 all requests seen", mem_q.size(), 0);
    chk(su_q.size() == 0, "R7 all setup words seen", su_q.size(), 0);
    chk(cmd_ready == 1'b1, "R9 ready after replies", cmd_ready, 1);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
    end
  end
endmodule